// File: doc/BRIEF.md
# Physical Register Free List

This block keeps the pool of physical register numbers that a register renaming stage can hand to newly decoded instructions. It is a circular queue of depth `NUM_PREGS - NUM_ARCH_REGS`. Several allocation slots can take entries from the head in one cycle. Several release slots can append entries at the tail in the same cycle. After reset, every physical register above the architectural ones is free.

Each granted allocation returns two values: the physical register number and the queue position it came from. The renaming stage keeps the position with the instruction. When a misprediction or exception redirect arrives, it sends that saved position back. The head then jumps straight to it, so every wrong-path allocation is reclaimed in one cycle. Released registers are the previous mappings of committed instructions. Their tail writes go ahead regardless of any redirect.

A queue position is a pointer of `log2(DEPTH)+1` bits. The low bits index the storage and the top bit is a wrap flag. With the wrap flag, a full queue and an empty queue have different head/tail pairs. `DEPTH` must be a power of two, and `ALLOC_W` and `REL_W` must not exceed it.

Top module: `preg_free_list`

## Requirements
- R1: After reset the queue holds DEPTH entries, with position p (p = 0 .. DEPTH-1) holding register NUM_ARCH_REGS + p. The head pointer is 0 and the tail pointer is DEPTH, so every slot reports canAlloc high.
- R2: `allocPreg[k]` is the register stored at position head + n, where n is the number of slots below k with `allocReq` high. A slot without a request consumes nothing.
- R3: `canAlloc[k]` is high exactly when there is no redirect and the free count (tail − head) is greater than n. Grants therefore always form a prefix of the requesting slots.
- R4: `allocPtr[k]` equals head + n, where n is the number of slots below k with `allocReq` high. It is a full pointer: the low log2(DEPTH) bits are the storage index and the top bit is the wrap flag.
- R5: Without a redirect, the head advances on the next edge by the number of slots that had both `allocReq` and `canAlloc` high.
- R6: Each release slot with `relValid` high writes `relPreg` at the tail. Releases are taken in slot order, lowest slot first, and skip invalid slots. Released registers come out of allocation after all entries that were already queued, in first-in first-out order.
- R7: While `redirectValid` is high, every `canAlloc` is low. On the next edge the head takes `redirectPtr`. After that, allocation returns the same registers that were previously handed out from those positions.
- R8: Releases presented in the same cycle as a redirect are still appended to the tail.
- R9: When the free count is zero, no slot can allocate. Once a release arrives, slot 0 can allocate again. Full and empty are distinguished by the wrap flag.
- R10: When an allocation position passes the end of the storage, its index restarts at 0 and the wrap flag toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | ALLOC_W | Per-slot allocation request |
| canAlloc | output | ALLOC_W | Per-slot grant availability |
| allocPreg | output | ALLOC_W x PREG_W | Register number offered to each slot |
| allocPtr | output | ALLOC_W x PW | Queue position (with wrap flag) used by each slot |
| relValid | input | REL_W | Per-slot release strobe |
| relPreg | input | REL_W x PREG_W | Register number being released |
| redirectValid | input | 1 | Roll the head back this cycle |
| redirectPtr | input | PW | Saved position the head returns to |

## Verification
The bench builds the block with 48 physical and 32 architectural registers, which gives a 16-entry queue, and with four allocation slots and two release slots. The shallow queue lets a few bursts of four grants drain it to empty. Partial grants then occur with the queue nearly empty, and the wrap flag turns over within a handful of cycles. Random traffic then mixes releases, redirects to earlier saved positions and sparse request masks across many wraps. A second release slot makes release ordering observable.

// File: rtl/fl_ctrl.sv
module fl_ctrl #(
  parameter int ALLOC_W = 4,
  parameter int REL_W   = 4,
  parameter int DEPTH   = 32,
  parameter int AW      = 5,
  parameter int PW      = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ALLOC_W-1:0]            allocReq,
  input  logic [REL_W-1:0]              relValid,
  input  logic                          redirectValid,
  input  logic [PW-1:0]                 redirectPtr,
  output logic [ALLOC_W-1:0]            canAlloc,
  output logic [ALLOC_W-1:0][PW-1:0]    allocPtr,
  output logic [REL_W-1:0][AW-1:0]      relIdx
);

  logic [PW-1:0] headQ;
  logic [PW-1:0] tailQ;
  logic [PW-1:0] freeCnt;
  logic [PW-1:0] grantCnt;
  logic [PW-1:0] reqBefore [ALLOC_W+1];
  logic [PW-1:0] relBefore [REL_W+1];

  assign freeCnt = tailQ - headQ;

  // running count of requesting slots below each slot
  always_comb begin
    reqBefore[0] = '0;
    for (int k = 0; k < ALLOC_W; k++) begin
      reqBefore[k+1] = reqBefore[k] + PW'(allocReq[k]);
    end
  end

  // running count of valid releases below each release slot
  always_comb begin
    relBefore[0] = '0;
    for (int j = 0; j < REL_W; j++) begin
      relBefore[j+1] = relBefore[j] + PW'(relValid[j]);
    end
  end

  for (genvar k = 0; k < ALLOC_W; k++) begin : gSlot
    assign canAlloc[k] = !redirectValid && (freeCnt > reqBefore[k]);
    assign allocPtr[k] = headQ + reqBefore[k];
  end

  for (genvar j = 0; j < REL_W; j++) begin : gRel
    assign relIdx[j] = AW'(tailQ + relBefore[j]);
  end

  always_comb begin
    grantCnt = '0;
    for (int k = 0; k < ALLOC_W; k++) begin
      grantCnt = grantCnt + PW'(allocReq[k] & canAlloc[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= PW'(DEPTH);
    end else begin
      tailQ <= tailQ + relBefore[REL_W];
      if (redirectValid) headQ <= redirectPtr;
      else               headQ <= headQ + grantCnt;
    end
  end

endmodule

// File: rtl/fl_store.sv
module fl_store #(
  parameter int ALLOC_W = 4,
  parameter int REL_W   = 4,
  parameter int DEPTH   = 32,
  parameter int AW      = 5,
  parameter int PREG_W  = 6,
  parameter int BASE    = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ALLOC_W-1:0][AW-1:0]        allocIdx,
  input  logic [REL_W-1:0]                  relValid,
  input  logic [REL_W-1:0][AW-1:0]          relIdx,
  input  logic [REL_W-1:0][PREG_W-1:0]      relPreg,
  output logic [ALLOC_W-1:0][PREG_W-1:0]    allocPreg
);

  logic [PREG_W-1:0] slotMem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        slotMem[i] <= PREG_W'(BASE + i);
      end
    end else begin
      for (int j = 0; j < REL_W; j++) begin
        if (relValid[j]) slotMem[relIdx[j]] <= relPreg[j];
      end
    end
  end

  for (genvar k = 0; k < ALLOC_W; k++) begin : gRead
    assign allocPreg[k] = slotMem[allocIdx[k]];
  end

endmodule

// File: rtl/preg_free_list.sv
module preg_free_list #(
  parameter int NUM_PREGS     = 64,
  parameter int NUM_ARCH_REGS = 32,
  parameter int ALLOC_W       = 4,
  parameter int REL_W         = 4,
  localparam int DEPTH        = NUM_PREGS - NUM_ARCH_REGS,
  localparam int AW           = $clog2(DEPTH),
  localparam int PW           = AW + 1,
  localparam int PREG_W       = $clog2(NUM_PREGS)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ALLOC_W-1:0]                allocReq,
  output logic [ALLOC_W-1:0]                canAlloc,
  output logic [ALLOC_W-1:0][PREG_W-1:0]    allocPreg,
  output logic [ALLOC_W-1:0][PW-1:0]        allocPtr,
  input  logic [REL_W-1:0]                  relValid,
  input  logic [REL_W-1:0][PREG_W-1:0]      relPreg,
  input  logic                              redirectValid,
  input  logic [PW-1:0]                     redirectPtr
);

  logic [ALLOC_W-1:0][AW-1:0] allocIdx;
  logic [REL_W-1:0][AW-1:0]   relIdx;

  for (genvar k = 0; k < ALLOC_W; k++) begin : gIdx
    assign allocIdx[k] = allocPtr[k][AW-1:0];
  end

  fl_ctrl #(
    .ALLOC_W(ALLOC_W), .REL_W(REL_W), .DEPTH(DEPTH), .AW(AW), .PW(PW)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .allocReq     (allocReq),
    .relValid     (relValid),
    .redirectValid(redirectValid),
    .redirectPtr  (redirectPtr),
    .canAlloc     (canAlloc),
    .allocPtr     (allocPtr),
    .relIdx       (relIdx)
  );

  fl_store #(
    .ALLOC_W(ALLOC_W), .REL_W(REL_W), .DEPTH(DEPTH), .AW(AW),
    .PREG_W(PREG_W), .BASE(NUM_ARCH_REGS)
  ) uStore (
    .clk      (clk),
    .rstN     (rstN),
    .allocIdx (allocIdx),
    .relValid (relValid),
    .relIdx   (relIdx),
    .relPreg  (relPreg),
    .allocPreg(allocPreg)
  );

endmodule

// File: rtl/fl_checker.sv
module fl_checker #(
  parameter int ALLOC_W = 4,
  parameter int PW      = 6
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [ALLOC_W-1:0]         allocReq,
  input logic [ALLOC_W-1:0]         canAlloc,
  input logic [ALLOC_W-1:0][PW-1:0] allocPtr,
  input logic                       redirectValid,
  input logic [PW-1:0]              redirectPtr
);

  // R7: a redirect blocks every grant in its cycle
  assert_redirect_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (canAlloc == '0));

  // R7: the head (seen as slot 0 position) takes the redirect position
  assert_redirect_head_R7: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> (allocPtr[0] == $past(redirectPtr)));

  // R5: head advances by the grant count
  assert_head_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    !redirectValid |=> (allocPtr[0] ==
      PW'($past(allocPtr[0]) + PW'($countones($past(allocReq & canAlloc))))));

  for (genvar k = 1; k < ALLOC_W; k++) begin : gChk
    // R3: grants form a prefix
    assert_prefix_R3: assert property (@(posedge clk) disable iff (!rstN)
      canAlloc[k] |-> canAlloc[k-1]);
    // R4: positions step only over requesting slots
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
      allocPtr[k] == PW'(allocPtr[k-1] + PW'(allocReq[k-1])));
  end

endmodule

bind preg_free_list fl_checker #(.ALLOC_W(ALLOC_W), .PW(PW)) uChecker (
  .clk          (clk),
  .rstN         (rstN),
  .allocReq     (allocReq),
  .canAlloc     (canAlloc),
  .allocPtr     (allocPtr),
  .redirectValid(redirectValid),
  .redirectPtr  (redirectPtr)
);

// File: tb/test_preg_free_list.sv
module test_preg_free_list;
  localparam int NP = 48;
  localparam int NA = 32;
  localparam int A  = 4;
  localparam int R  = 2;
  localparam int D  = NP - NA;
  localparam int AW = $clog2(D);
  localparam int PW = AW + 1;
  localparam int PREG_W = $clog2(NP);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [A-1:0] allocReq = '0;
  logic [A-1:0] canAlloc;
  logic [A-1:0][PREG_W-1:0] allocPreg;
  logic [A-1:0][PW-1:0] allocPtr;
  logic [R-1:0] relValid = '0;
  logic [R-1:0][PREG_W-1:0] relPreg = '0;
  logic redirectValid = 1'b0;
  logic [PW-1:0] redirectPtr = '0;

  always #5 clk = ~clk;

  preg_free_list #(.NUM_PREGS(NP), .NUM_ARCH_REGS(NA), .ALLOC_W(A), .REL_W(R)) i_preg_free_list (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .canAlloc(canAlloc),
    .allocPreg(allocPreg), .allocPtr(allocPtr), .relValid(relValid),
    .relPreg(relPreg), .redirectValid(redirectValid), .redirectPtr(redirectPtr)
  );

  typedef struct {
    int    slot;
    bit    checkVal;
    bit    expCan;
    int    expPreg;
    int    expPtr;
    string tag;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int mMem [D];
  int mHead = 0;
  int mTail = D;
  int allocSince = 0;

  task automatic step(input logic [A-1:0] req, input logic [R-1:0] rv,
                      input int rp0, input int rp1, input bit redir,
                      input int target, input string tag);
    int free, rb, g, n;
    item_t it;
    @(negedge clk);
    allocReq = req;
    relValid = rv;
    relPreg[0] = PREG_W'(rp0);
    relPreg[1] = PREG_W'(rp1);
    redirectValid = redir;
    redirectPtr = PW'(target % (2 * D));
    free = mTail - mHead;
    rb = 0;
    g = 0;
    for (int k = 0; k < A; k++) begin
      it.slot = k;
      it.expCan = !redir && (free > rb);
      it.checkVal = it.expCan && req[k];
      it.expPreg = mMem[(mHead + rb) % D];
      it.expPtr = (mHead + rb) % (2 * D);
      it.tag = tag;
      expQ.push_back(it);
      if (req[k]) begin
        if (it.expCan) g++;
        rb++;
      end
    end
    n = 0;
    for (int j = 0; j < R; j++) begin
      if (rv[j]) begin
        mMem[(mTail + n) % D] = (j == 0) ? rp0 : rp1;
        n++;
      end
    end
    mTail += n;
    if (redir) begin
      mHead = target;
      allocSince = 0;
    end else begin
      mHead += g;
      allocSince += g;
    end
  endtask

  // monitor: compares expected items once outputs have settled
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        checks++;
        if (canAlloc[it.slot] !== it.expCan) begin
          fails++;
          $display("FAIL %s slot %0d canAlloc actual %0b expected %0b",
                   it.tag, it.slot, canAlloc[it.slot], it.expCan);
        end
        if (it.checkVal) begin
          checks++;
          if (int'(allocPreg[it.slot]) != it.expPreg) begin
            fails++;
            $display("FAIL %s slot %0d allocPreg actual %0d expected %0d",
                     it.tag, it.slot, allocPreg[it.slot], it.expPreg);
          end
          checks++;
          if (int'(allocPtr[it.slot]) != it.expPtr) begin
            fails++;
            $display("FAIL %s slot %0d allocPtr actual %0d expected %0d",
                     it.tag, it.slot, allocPtr[it.slot], it.expPtr);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) mMem[i] = NA + i;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, all slots available, first registers handed out
    step(4'b0000, 2'b00, 0, 0, 0, 0, "R1");
    step(4'b1111, 2'b00, 0, 0, 0, 0, "R1");
    // R2: sparse request mask
    step(4'b0101, 2'b00, 0, 0, 0, 0, "R2");
    // R5: head advanced by grants
    step(4'b1111, 2'b00, 0, 0, 0, 0, "R5");
    // R6: releases appended at the tail
    step(4'b0011, 2'b11, 5, 6, 0, 0, "R6");
    // R3: count check with a partially refilled queue
    step(4'b1111, 2'b00, 0, 0, 0, 0, "R3");
    // R10: wrap flag set, released registers emerge, partial grant
    step(4'b1111, 2'b00, 0, 0, 0, 0, "R10");
    // R9: empty queue blocks everything
    step(4'b1111, 2'b00, 0, 0, 0, 0, "R9");
    // R7 with R8: redirect back to position 12 while releasing register 7
    step(4'b1111, 2'b01, 7, 0, 1, 12, "R7");
    step(4'b1111, 2'b00, 0, 0, 0, 0, "R7");
    step(4'b1111, 2'b00, 0, 0, 0, 0, "R8");
    // R9: recover from empty after a single release
    step(4'b0000, 2'b10, 0, 9, 0, 0, "R9");
    step(4'b0001, 2'b00, 0, 0, 0, 0, "R9");
    // R4: mixed random traffic
    for (int t = 0; t < 400; t++) begin
      logic [A-1:0] req;
      logic [R-1:0] rv;
      int nrel, back, tgt;
      bit redir;
      req = A'($urandom);
      rv = R'($urandom);
      nrel = $countones(rv);
      while (mTail + nrel - mHead > D) begin
        rv = rv & (rv - 1'b1);
        nrel = $countones(rv);
      end
      redir = (($urandom % 8) == 0) && (allocSince > 0);
      tgt = mHead;
      if (redir) begin
        back = 1 + ($urandom % allocSince);
        tgt = mHead - back;
        while (tgt < mHead && mTail + nrel > tgt + D) tgt++;
      end
      step(req, rv, $urandom % NP, $urandom % NP, redir, tgt, "R4");
    end
    step(4'b0000, 2'b00, 0, 0, 0, 0, "R4");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule